// File: doc/BRIEF.md
# Conditional Skip Execution Unit

This unit executes the conditional-skip group of a single-accumulator controller. Each instruction arrives with a start strobe and carries an operation code, the accumulator value, one operand (an immediate or a fetched memory byte), a bit index and a hint that says whether a memory destination is RAM or a system register. One clock later the unit presents the result. Alongside it come the write target (accumulator or memory), the updated zero and carry flags, a request to skip the next instruction, and the number of cycles the instruction costs.

The program counter logic uses the skip request and the cycle count. The register file or memory port uses the write target and the result. The unit does not fetch operands or advance the program counter itself. It also holds the zero and carry flags, and only the compare operation changes them.

Top module: `skip_exec_unit`

## Requirements
- R1: While reset is active, and after it until the first start, `done_o`, `skip_o`, `wr_acc_o`, `wr_mem_o` and `res_o` are 0, `cyc_o` is 0, and both flags read 0.
- R2: Compare (code 0) outputs A minus operand (mod 256) on `res_o`. It sets the zero flag to (A == operand) and the carry flag to (A >= operand, no borrow). It writes nowhere and requests a skip exactly when A equals the operand.
- R3: Accumulator increment (code 1) outputs operand+1 (mod 256) with `wr_acc_o`=1 and skips when that value is zero.
- R4: Memory increment (code 2) outputs operand+1 (mod 256) with `wr_mem_o`=1 and skips when that value is zero.
- R5: Accumulator decrement (code 3) and memory decrement (code 4) output operand-1 (mod 256) to the accumulator or to memory respectively, and skip when that value is zero.
- R6: Bit test codes 5 (skip when the bit is 0) and 6 (skip when the bit is 1) examine the operand bit selected by the 3-bit index (0 = LSB, 7 = MSB). They pass the operand to `res_o` and write nowhere.
- R7: Every code other than 0 leaves both flags unchanged.
- R8: `cyc_o` is 1, plus 1 when the skip is taken, plus 1 more when the code writes memory and `ram_i` is 1. A system-register target (`ram_i`=0) adds nothing.
- R9: Results appear one clock after the start edge, and `done_o` is high for exactly that cycle. Without a start, `done_o` is 0 and `res_o`, `skip_o` and `cyc_o` hold their last values.
- R10: Code 7 is reserved. It gives `res_o`=0, no write, no skip, `cyc_o`=1 and unchanged flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Execute the presented instruction |
| op_i | input | 3 | Operation code (0..7) |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Memory or immediate operand |
| bit_i | input | 3 | Bit index for bit tests |
| ram_i | input | 1 | Memory destination is RAM (1) or a system register (0) |
| res_o | output | 8 | Result value |
| wr_acc_o | output | 1 | Result goes to the accumulator |
| wr_mem_o | output | 1 | Result goes back to memory |
| skip_o | output | 1 | Skip the next instruction |
| cyc_o | output | 2 | Cycles the instruction consumes |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry flag |
| done_o | output | 1 | Outputs valid this cycle |

## Verification
A wrong flag state is visible on `zf_o` and `cf_o` one clock after the instruction that corrupted it. It stays visible through every later non-compare instruction, because those must hold the flags. A faulty skip or write decode shows up on `skip_o`, `wr_acc_o` or `wr_mem_o` in the same cycle as `done_o`. It also shows up on `cyc_o`, because the cost depends on both. The mod-256 wraps, the index ends 0 and 7, and the RAM versus system-register cost split are each driven directly, so an off-by-one or an inverted condition appears in the result cycle of the instruction that triggers it.

// File: rtl/skip_pkg.sv
package skip_pkg;
  localparam int unsigned OP_W  = 3;
  localparam int unsigned CYC_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_CMP    = 3'd0,
    OP_INC_A  = 3'd1,
    OP_INC_M  = 3'd2,
    OP_DEC_A  = 3'd3,
    OP_DEC_M  = 3'd4,
    OP_BT_CLR = 3'd5,
    OP_BT_SET = 3'd6,
    OP_RSVD   = 3'd7
  } skip_op_e;

  typedef struct packed {
    logic wr_acc;
    logic wr_mem;
    logic skip;
    logic flag_we;
    logic use_diff;
    logic use_step;
    logic use_pass;
  } skip_ctl_t;
endpackage

// File: rtl/skip_arith.sv
module skip_arith #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          dec_i,
  output logic [DW-1:0] diff_o,
  output logic          eq_o,
  output logic          nb_o,
  output logic [DW-1:0] step_o,
  output logic          step_zero_o
);
  function automatic logic [DW:0] sub_ext(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return {1'b0, a} - {1'b0, b};
  endfunction

  function automatic logic [DW-1:0] step_val(input logic [DW-1:0] v, input logic dn);
    return dn ? v - DW'(1) : v + DW'(1);
  endfunction

  logic [DW:0] wide;

  always_comb begin
    wide        = sub_ext(acc_i, opnd_i);
    diff_o      = wide[DW-1:0];
    nb_o        = ~wide[DW];
    eq_o        = (diff_o == '0);
    step_o      = step_val(opnd_i, dec_i);
    step_zero_o = (step_o == '0);
  end
endmodule

// File: rtl/skip_bitpick.sv
module skip_bitpick #(
  parameter int unsigned DW  = 8,
  localparam int unsigned IW = $clog2(DW)
) (
  input  logic [DW-1:0] val_i,
  input  logic [IW-1:0] idx_i,
  output logic          bit_o
);
  logic [DW-1:0] hit;

  for (genvar g = 0; g < DW; g++) begin : g_sel
    assign hit[g] = val_i[g] & (idx_i == IW'(g));
  end

  assign bit_o = |hit;
endmodule

// File: rtl/skip_decide.sv
module skip_decide
  import skip_pkg::*;
(
  input  skip_op_e  op_i,
  input  logic      eq_i,
  input  logic      step_zero_i,
  input  logic      bit_i,
  output skip_ctl_t ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (op_i)
      OP_CMP: begin
        ctl_o.flag_we  = 1'b1;
        ctl_o.use_diff = 1'b1;
        ctl_o.skip     = eq_i;
      end
      OP_INC_A, OP_DEC_A: begin
        ctl_o.wr_acc   = 1'b1;
        ctl_o.use_step = 1'b1;
        ctl_o.skip     = step_zero_i;
      end
      OP_INC_M, OP_DEC_M: begin
        ctl_o.wr_mem   = 1'b1;
        ctl_o.use_step = 1'b1;
        ctl_o.skip     = step_zero_i;
      end
      OP_BT_CLR: begin
        ctl_o.use_pass = 1'b1;
        ctl_o.skip     = ~bit_i;
      end
      OP_BT_SET: begin
        ctl_o.use_pass = 1'b1;
        ctl_o.skip     = bit_i;
      end
      default: ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/skip_cost.sv
module skip_cost
  import skip_pkg::*;
(
  input  logic             skip_i,
  input  logic             wr_mem_i,
  input  logic             ram_i,
  output logic [CYC_W-1:0] cyc_o
);
  function automatic logic [CYC_W-1:0] cost(input logic s, input logic m, input logic r);
    logic [CYC_W-1:0] c;
    c = CYC_W'(1);
    if (s) c = c + CYC_W'(1);
    if (m && r) c = c + CYC_W'(1);
    return c;
  endfunction

  assign cyc_o = cost(skip_i, wr_mem_i, ram_i);
endmodule

// File: rtl/skip_exec_unit.sv
module skip_exec_unit
  import skip_pkg::*;
#(
  parameter int unsigned DW  = 8,
  localparam int unsigned IW = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [DW-1:0]    acc_i,
  input  logic [DW-1:0]    opnd_i,
  input  logic [IW-1:0]    bit_i,
  input  logic             ram_i,
  output logic [DW-1:0]    res_o,
  output logic             wr_acc_o,
  output logic             wr_mem_o,
  output logic             skip_o,
  output logic [CYC_W-1:0] cyc_o,
  output logic             zf_o,
  output logic             cf_o,
  output logic             done_o
);
  skip_op_e         op;
  logic [DW-1:0]    diff, step, res_c;
  logic             eq, nb, step_zero, pick;
  skip_ctl_t        ctl;
  logic [CYC_W-1:0] cyc_c;
  logic             cmp_ev;

  assign op = skip_op_e'(op_i);

  skip_arith #(.DW(DW)) u_arith (
    .acc_i(acc_i), .opnd_i(opnd_i),
    .dec_i(op == OP_DEC_A || op == OP_DEC_M),
    .diff_o(diff), .eq_o(eq), .nb_o(nb),
    .step_o(step), .step_zero_o(step_zero)
  );

  skip_bitpick #(.DW(DW)) u_pick (
    .val_i(opnd_i), .idx_i(bit_i), .bit_o(pick)
  );

  skip_decide u_dec (
    .op_i(op), .eq_i(eq), .step_zero_i(step_zero), .bit_i(pick), .ctl_o(ctl)
  );

  skip_cost u_cost (
    .skip_i(ctl.skip), .wr_mem_i(ctl.wr_mem), .ram_i(ram_i), .cyc_o(cyc_c)
  );

  always_comb begin
    res_c = '0;
    if (ctl.use_diff) res_c = diff;
    if (ctl.use_step) res_c = step;
    if (ctl.use_pass) res_c = opnd_i;
  end

  assign cmp_ev = start_i && ctl.flag_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_o    <= '0;
      wr_acc_o <= 1'b0;
      wr_mem_o <= 1'b0;
      skip_o   <= 1'b0;
      cyc_o    <= '0;
      zf_o     <= 1'b0;
      cf_o     <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        res_o    <= res_c;
        wr_acc_o <= ctl.wr_acc;
        wr_mem_o <= ctl.wr_mem;
        skip_o   <= ctl.skip;
        cyc_o    <= cyc_c;
      end else begin
        wr_acc_o <= 1'b0;
        wr_mem_o <= 1'b0;
      end
      if (cmp_ev) begin
        zf_o <= eq;
        cf_o <= nb;
      end
    end
  end

  // R9: one result pulse per start
  p_done_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  p_no_stray_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);
  // R7: flags move only on a compare
  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_ev |=> ($stable(zf_o) && $stable(cf_o)));
  // R2: an equal compare leaves zero flag set and requests skip
  p_cmp_eq_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_ev |=> (zf_o == skip_o) && !wr_acc_o && !wr_mem_o);
  // R3 / R5: writes skip exactly on a zero result
  p_zero_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (wr_acc_o || wr_mem_o)) |-> (skip_o == (res_o == '0)));
  p_one_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_acc_o && wr_mem_o));
  // R8: cost bounds
  p_cost_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && skip_o) |-> (cyc_o >= CYC_W'(2)));
  p_cost_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cyc_o == CYC_W'(3)) |-> (skip_o && wr_mem_o));
  p_cost_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cyc_o != '0));
endmodule

// File: tb/skip_exec_unit_test.sv
module skip_exec_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0;
  logic [2:0] bit_i = '0;
  logic       ram_i = 1'b0;
  logic [7:0] res_o;
  logic       wr_acc_o, wr_mem_o, skip_o, zf_o, cf_o, done_o;
  logic [1:0] cyc_o;

  int checks = 0;
  int fails  = 0;
  logic ez = 1'b0, ec = 1'b0;

  always #4 clk = ~clk;

  skip_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .bit_i(bit_i), .ram_i(ram_i),
    .res_o(res_o), .wr_acc_o(wr_acc_o), .wr_mem_o(wr_mem_o),
    .skip_o(skip_o), .cyc_o(cyc_o), .zf_o(zf_o), .cf_o(cf_o), .done_o(done_o)
  );

  // op, acc, opnd, idx, ram, exp_res, exp_skip, exp_cyc
  localparam int NV = 17;
  localparam logic [33:0] VEC [NV] = '{
    {3'd0, 8'h35, 8'h35, 3'd0, 1'b0, 8'h00, 1'b1, 2'd2}, // R2 equal
    {3'd0, 8'h10, 8'h20, 3'd0, 1'b0, 8'hF0, 1'b0, 2'd1}, // R2 borrow
    {3'd0, 8'h80, 8'h7F, 3'd0, 1'b1, 8'h01, 1'b0, 2'd1}, // R2 no borrow
    {3'd1, 8'h00, 8'hFF, 3'd0, 1'b1, 8'h00, 1'b1, 2'd2}, // R3 wrap
    {3'd1, 8'h00, 8'h41, 3'd0, 1'b0, 8'h42, 1'b0, 2'd1}, // R3
    {3'd2, 8'h00, 8'hFF, 3'd0, 1'b1, 8'h00, 1'b1, 2'd3}, // R4 RAM
    {3'd2, 8'h00, 8'hFF, 3'd0, 1'b0, 8'h00, 1'b1, 2'd2}, // R4 sysreg
    {3'd2, 8'h00, 8'h07, 3'd0, 1'b1, 8'h08, 1'b0, 2'd2}, // R4
    {3'd3, 8'h00, 8'h01, 3'd0, 1'b0, 8'h00, 1'b1, 2'd2}, // R5
    {3'd3, 8'h00, 8'h00, 3'd0, 1'b0, 8'hFF, 1'b0, 2'd1}, // R5 wrap
    {3'd4, 8'h00, 8'h01, 3'd0, 1'b1, 8'h00, 1'b1, 2'd3}, // R5 RAM
    {3'd4, 8'h00, 8'h90, 3'd0, 1'b0, 8'h8F, 1'b0, 2'd1}, // R5 sysreg
    {3'd5, 8'h00, 8'hF7, 3'd3, 1'b0, 8'hF7, 1'b1, 2'd2}, // R6 clear hit
    {3'd5, 8'h00, 8'hF7, 3'd7, 1'b0, 8'hF7, 1'b0, 2'd1}, // R6 msb
    {3'd6, 8'h00, 8'h01, 3'd0, 1'b0, 8'h01, 1'b1, 2'd2}, // R6 lsb
    {3'd6, 8'h00, 8'h01, 3'd6, 1'b1, 8'h01, 1'b0, 2'd1}, // R6 miss
    {3'd7, 8'h00, 8'hAA, 3'd2, 1'b1, 8'h00, 1'b0, 2'd1}  // R10
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] ix, input logic r);
    @(negedge clk);
    op_i = op; acc_i = a; opnd_i = b; bit_i = ix; ram_i = r; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (op == 3'd0) begin
      ez = (a == b);
      ec = (a >= b);
    end
  endtask

  initial begin : watchdog
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "done", done_o, 0);
    chk("R1", "res", res_o, 0);
    chk("R1", "cyc", cyc_o, 0);
    chk("R1", "flags", {zf_o, cf_o}, 0);
    chk("R1", "wr", {wr_acc_o, wr_mem_o, skip_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle done", done_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      logic [2:0] op;
      v  = VEC[i];
      op = v[33:31];
      issue(op, v[30:23], v[22:15], v[14:12], v[11]);
      chk("R9", "done", done_o, 1);
      chk(op == 3'd0 ? "R2" : (op == 3'd7 ? "R10" : "R3-6"), "res", res_o, v[10:3]);
      chk(op >= 3'd5 ? "R6" : "R2-5", "skip", skip_o, v[2]);
      chk("R8", "cyc", cyc_o, v[1:0]);
      chk("R5", "wr_acc", wr_acc_o, (op == 3'd1 || op == 3'd3));
      chk("R4", "wr_mem", wr_mem_o, (op == 3'd2 || op == 3'd4));
      chk(op == 3'd0 ? "R2" : "R7", "zf", zf_o, ez);
      chk(op == 3'd0 ? "R2" : "R7", "cf", cf_o, ec);
    end

    // R9 hold without start
    issue(3'd1, 8'h00, 8'h41, 3'd0, 1'b0);
    @(negedge clk);
    chk("R9", "done low", done_o, 0);
    chk("R9", "res held", res_o, 8'h42);
    chk("R9", "cyc held", cyc_o, 1);

    // R7 flags survive a run of non-compare ops after a set compare
    issue(3'd0, 8'h5A, 8'h5A, 3'd0, 1'b0);
    issue(3'd4, 8'h00, 8'h01, 3'd0, 1'b1);
    issue(3'd6, 8'h00, 8'h00, 3'd5, 1'b0);
    chk("R7", "flags", {zf_o, cf_o}, 2'b11);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "reset flags", {zf_o, cf_o}, 0);
    chk("R1", "reset res", res_o, 0);
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule